// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Core

This block is the core of a small field-configurable logic device. Twelve dedicated inputs and the feedback of ten output cells make 22 signals. Each signal enters a wired-AND plane in true and inverted form. Every plane row is one product term. The rows are grouped per output cell, and the groups differ in size: the cells at the two ends get 8 sum terms each, and the count rises by 2 per cell towards the middle pair, which gets 16 each. Every cell also has one private term that drives its pad enable. Two more terms are shared by all cells: one clears every register and one presets every register at an array clock edge.

Each output cell can be set as registered or combinational, and as active-high or active-low. Dedicated input 0 is the shared array clock and can also be used in product terms. Every signal in the block, including the array-clock edge detector, runs on one system clock. The configuration is loaded as one bit vector, shifted in serially while the load strobe is high. The control machine has three states. CFG_BLANK is the state after reset. CFG_SHIFT is held while the strobe is high. CFG_RUN holds the logic live. The transitions are CFG_BLANK to CFG_SHIFT, CFG_SHIFT to CFG_RUN and CFG_RUN to CFG_SHIFT. A state with a low strobe and no transition stays where it is.

Top module: `pld_core`

## Requirements
- R1: A configuration bit of 1 connects a plane column to a row. A row with no connected column gives 1. A row that has both forms of one signal connected gives 0. Signal s drives column 2s in true form and column 2s+1 in inverted form. Signals 0..11 are pin_in[0..11] and signals 12..21 are the feedbacks of cells 0..9.
- R2: Row r, column c sits at configuration bit r*44+c. Row 0 is the shared clear term and row 131 is the shared preset term. Rows 1..130 hold one block per cell in cell order, and each block is the enable row followed by the cell's sum rows. The sum-row counts for cells 0..9 are 8,10,12,14,16,16,14,12,10,8.
- R3: Configuration bit 5808+2k sets the polarity of cell k (1 = active-high). Bit 5809+2k sets its mode (1 = combinational, 0 = registered).
- R4: A registered cell loads the OR of its sum rows on the system clock edge that ends a cycle in which pin_in[0] is 1 and was 0 in the cycle before. Otherwise the register holds its value. The pad shows the register value, inverted when the cell is active-low.
- R5: A combinational cell drives the OR of its sum rows to its pad in the same cycle, inverted when the cell is active-low.
- R6: io_oe[k] follows the enable row of cell k while the core is in CFG_RUN, and is 0 in every other state.
- R7: When the shared clear term is 1 in CFG_RUN, every register is 0 after the next system clock edge. This takes priority over the preset and over an array clock edge.
- R8: When the shared preset term is 1 at an array clock edge and the clear term is 0, every register becomes 1.
- R9: The feedback of a registered cell is its register. The feedback of a combinational cell is its pad level io_in[k].
- R10: While cfg_load is 1, cfg_data is shifted in one bit per clock. The first bit goes to bit 0 of the 5828-bit vector. The core leaves CFG_RUN, holds io_oe at 0 and clears every register. The new vector takes effect once cfg_load returns to 0.
- R11: After reset the core is in CFG_BLANK, with io_oe at 0 and all registers at 0, until a load completes.
- R12: pin_in[0] can be used in product terms like any other input, even though it is also the array clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the shift of the configuration and all registers use it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Configuration shift strobe |
| cfg_data | input | 1 | Serial configuration bit |
| pin_in | input | 12 | Dedicated inputs; bit 0 is also the array clock |
| io_in | input | 10 | Pad levels of the ten I/O cells |
| io_out | output | 10 | Values the cells drive towards their pads |
| io_oe | output | 10 | Pad drive enables |

## Verification
Two events can land on the same array clock edge. The shared preset term and the shared clear term can both be true. A preset can also coincide with the edge itself. The bench provokes both cases by raising pin_in[0] while the inputs that form these terms are held high. It checks that the preset alone drives every register to 1, and that the clear wins when both terms are true at once. Starting a reload on the same cycle as an array edge is also covered. There the result is judged on the pads: all enables must be off and the registers cleared. A behavioural model that evaluates the loaded configuration bit by bit is compared against the pads on every clock.

// File: rtl/pld_pkg.sv
package pld_pkg;

    typedef enum logic [1:0] {
        CFG_BLANK = 2'd0,
        CFG_SHIFT = 2'd1,
        CFG_RUN   = 2'd2
    } cfg_state_t;

    // Sum-term count of cell k: rises by step towards the middle, then falls.
    function automatic int pt_count(input int k, input int n_io,
                                    input int min_pt, input int step);
        int half;
        half = n_io / 2;
        if (k < half)
            return min_pt + step * k;
        return min_pt + step * (n_io - 1 - k);
    endfunction

    // Row index of the enable row of cell k; row 0 is the shared clear term.
    function automatic int block_base(input int k, input int n_io,
                                      input int min_pt, input int step);
        int b;
        b = 1;
        for (int j = 0; j < k; j++)
            b = b + pt_count(j, n_io, min_pt, step) + 1;
        return b;
    endfunction

    // Total row count: clear row, all cell blocks, preset row.
    function automatic int total_rows(input int n_io, input int min_pt,
                                      input int step);
        return block_base(n_io, n_io, min_pt, step) + 1;
    endfunction

endpackage

// File: rtl/pld_cfg_ctrl.sv
module pld_cfg_ctrl
    import pld_pkg::*;
#(
    parameter int CFG_W = 5828
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_data,
    output logic             run,
    output logic [CFG_W-1:0] fuse
);

    cfg_state_t state, state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= CFG_BLANK;
        else
            state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            CFG_BLANK: state_nxt = cfg_load ? CFG_SHIFT : CFG_BLANK;
            CFG_SHIFT: state_nxt = cfg_load ? CFG_SHIFT : CFG_RUN;
            CFG_RUN:   state_nxt = cfg_load ? CFG_SHIFT : CFG_RUN;
            default:   state_nxt = CFG_BLANK;
        endcase
    end

    // Outputs
    always_comb begin
        run = (state == CFG_RUN);
    end

    // Serial map, first bit ends at index 0
    always_ff @(posedge clk) begin
        if (cfg_load)
            fuse <= {cfg_data, fuse[CFG_W-1:1]};
    end

    a_r10_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> fuse[CFG_W-1] == $past(cfg_data));
    a_r10_load_leaves_run: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> !run);
    a_r10_release_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CFG_SHIFT && !cfg_load) |=> run);
    a_r11_blank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CFG_BLANK && !cfg_load) |=> state == CFG_BLANK);

endmodule

// File: rtl/pld_and_plane.sv
module pld_and_plane #(
    parameter int N_COL = 44,
    parameter int N_ROW = 132
) (
    input  logic [N_COL-1:0]       cols,
    input  logic [N_ROW*N_COL-1:0] fuse,
    output logic [N_ROW-1:0]       pt
);

    // A row is true when every connected column is true.
    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        assign pt[r] = &(cols | ~fuse[r*N_COL +: N_COL]);
    end

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clk_edge,
    input  logic sum,
    input  logic oe_pt,
    input  logic ar,
    input  logic sp,
    input  logic comb_mode,
    input  logic act_high,
    input  logic pad_in,
    output logic pad_out,
    output logic pad_oe,
    output logic fb
);

    logic q;
    logic value;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= 1'b0;
        else if (!run)
            q <= 1'b0;
        else if (ar)
            q <= 1'b0;
        else if (clk_edge)
            q <= sp ? 1'b1 : sum;
    end

    always_comb begin
        value   = comb_mode ? sum : q;
        pad_out = act_high ? value : ~value;
        pad_oe  = run & oe_pt;
        fb      = comb_mode ? pad_in : q;
    end

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ar) |=> !q);
    a_r8_preset_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ar && clk_edge && sp) |=> q);
    a_r4_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ar && !clk_edge) |=> $stable(q));
    a_r10_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !q);

endmodule

// File: rtl/pld_core.sv
module pld_core
    import pld_pkg::*;
#(
    parameter int N_IN    = 12,
    parameter int N_IO    = 10,
    parameter int MIN_PT  = 8,
    parameter int PT_STEP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_load,
    input  logic            cfg_data,
    input  logic [N_IN-1:0] pin_in,
    input  logic [N_IO-1:0] io_in,
    output logic [N_IO-1:0] io_out,
    output logic [N_IO-1:0] io_oe
);

    localparam int N_SIG   = N_IN + N_IO;
    localparam int N_COL   = 2 * N_SIG;
    localparam int N_ROW   = total_rows(N_IO, MIN_PT, PT_STEP);
    localparam int ARRAY_W = N_ROW * N_COL;
    localparam int CFG_W   = ARRAY_W + 2 * N_IO;
    localparam int AR_ROW  = 0;
    localparam int SP_ROW  = N_ROW - 1;

    logic             run;
    logic [CFG_W-1:0] fuse;
    logic [N_IO-1:0]  fb;
    logic [N_SIG-1:0] sig;
    logic [N_COL-1:0] cols;
    logic [N_ROW-1:0] pt;
    logic             pin0_q;
    logic             clk_edge;

    pld_cfg_ctrl #(.CFG_W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_data (cfg_data),
        .run      (run),
        .fuse     (fuse)
    );

    // Array clock: rising level of dedicated input 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pin0_q <= 1'b0;
        else
            pin0_q <= pin_in[0];
    end
    assign clk_edge = pin_in[0] & ~pin0_q;

    assign sig = {fb, pin_in};
    for (genvar s = 0; s < N_SIG; s++) begin : g_col
        assign cols[2*s]   = sig[s];
        assign cols[2*s+1] = ~sig[s];
    end

    pld_and_plane #(.N_COL(N_COL), .N_ROW(N_ROW)) u_plane (
        .cols (cols),
        .fuse (fuse[ARRAY_W-1:0]),
        .pt   (pt)
    );

    for (genvar k = 0; k < N_IO; k++) begin : g_cell
        localparam int BASE = block_base(k, N_IO, MIN_PT, PT_STEP);
        localparam int NPT  = pt_count(k, N_IO, MIN_PT, PT_STEP);
        logic sum;
        assign sum = |pt[BASE+1 +: NPT];

        pld_macrocell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run),
            .clk_edge  (clk_edge),
            .sum       (sum),
            .oe_pt     (pt[BASE]),
            .ar        (pt[AR_ROW]),
            .sp        (pt[SP_ROW]),
            .comb_mode (fuse[ARRAY_W + 2*k + 1]),
            .act_high  (fuse[ARRAY_W + 2*k]),
            .pad_in    (io_in[k]),
            .pad_out   (io_out[k]),
            .pad_oe    (io_oe[k]),
            .fb        (fb[k])
        );
    end

    a_r6_pads_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> io_oe == '0);
    a_r11_blank_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !run);

endmodule

// File: tb/pld_core_bench.sv
module pld_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_COL   = 44;
    localparam int N_ROW   = 132;
    localparam int ARRAY_W = N_ROW * N_COL;
    localparam int CFG_W   = ARRAY_W + 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic        cfg_data = 1'b0;
    logic [11:0] pin_in = '0;
    logic [9:0]  io_in = '0;
    logic [9:0]  io_out;
    logic [9:0]  io_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    pld_core u_pld_core (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_data(cfg_data),
        .pin_in(pin_in), .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
    );

    int    vectors = 0;
    int    miscompares = 0;
    string req = "R11";
    logic [CFG_W-1:0] prog;
    bit    mdl_fuse[$];
    int    mdl_mode = 0;         // 0 blank, 1 shifting, 2 live
    bit [9:0] mdl_q = '0;
    bit    mdl_prev0 = 1'b0;

    function automatic int pt_num(int k);
        return (k < 5) ? 8 + 2*k : 8 + 2*(9 - k);
    endfunction

    function automatic int oe_row(int k);
        int r = 1;
        for (int j = 0; j < k; j++) r += pt_num(j) + 1;
        return r;
    endfunction

    function automatic bit sigv(int s);
        if (s < 12) return pin_in[s];
        if (mdl_fuse[ARRAY_W + 2*(s-12) + 1]) return io_in[s-12];
        return mdl_q[s-12];
    endfunction

    function automatic bit term(int r);
        bit v = 1'b1;
        for (int s = 0; s < 22; s++) begin
            if (mdl_fuse[r*N_COL + 2*s] && !sigv(s)) v = 1'b0;
            if (mdl_fuse[r*N_COL + 2*s + 1] && sigv(s)) v = 1'b0;
        end
        return v;
    endfunction

    function automatic bit sumv(int k);
        for (int t = 0; t < pt_num(k); t++)
            if (term(oe_row(k) + 1 + t)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check_bit(string tag, bit act, bit exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        bit [9:0] e_oe = '0;
        bit [9:0] e_out = '0;
        if (mdl_mode == 2) begin
            for (int k = 0; k < 10; k++) begin
                bit val;
                e_oe[k] = term(oe_row(k));
                val = mdl_fuse[ARRAY_W + 2*k + 1] ? sumv(k) : mdl_q[k];
                e_out[k] = mdl_fuse[ARRAY_W + 2*k] ? val : ~val;
            end
        end
        vectors++;
        if (io_oe !== e_oe || (mdl_mode == 2 && io_out !== e_out)) begin
            miscompares++;
            $display("FAIL %s: io_oe=%b io_out=%b expected io_oe=%b io_out=%b",
                     req, io_oe, io_out, e_oe, e_out);
        end
    endtask

    task automatic advance_model();
        bit [9:0] nq = '0;
        bit edge_now = pin_in[0] && !mdl_prev0;
        if (mdl_mode == 2) begin
            bit ar = term(0);
            bit sp = term(N_ROW - 1);
            for (int k = 0; k < 10; k++) begin
                if (ar) nq[k] = 1'b0;
                else if (edge_now) nq[k] = sp ? 1'b1 : sumv(k);
                else nq[k] = mdl_q[k];
            end
        end
        mdl_q = nq;
        if (cfg_load) begin
            mdl_fuse.push_back(cfg_data);
            if (mdl_fuse.size() > CFG_W) void'(mdl_fuse.pop_front());
        end
        if (cfg_load) mdl_mode = 1;
        else if (mdl_mode == 1) mdl_mode = 2;
        mdl_prev0 = pin_in[0];
    endtask

    task automatic step();
        #1;
        compare_model();
        advance_model();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic con(int r, int s, bit neg);
        prog[r*N_COL + 2*s + int'(neg)] = 1'b1;
    endtask

    task automatic clear_row(int r);
        for (int c = 0; c < N_COL; c++) prog[r*N_COL + c] = 1'b0;
    endtask

    task automatic set_mode(int k, bit comb, bit high);
        prog[ARRAY_W + 2*k]     = high;
        prog[ARRAY_W + 2*k + 1] = comb;
    endtask

    task automatic load_prog();
        req = "R10";
        for (int i = 0; i < CFG_W; i++) begin
            cfg_load = 1'b1;
            cfg_data = prog[i];
            step();
            if (i == 2) check_bit("R10 pads off while loading", |io_oe, 1'b0);
        end
        cfg_load = 1'b0;
        cfg_data = 1'b0;
        step();
    endtask

    // Program A: 4-bit counter in cells 0..3 plus assorted cells
    task automatic build_a();
        prog = '1;
        clear_row(0); con(0, 6, 0); con(0, 7, 0);
        clear_row(N_ROW-1); con(N_ROW-1, 5, 0);
        for (int k = 0; k < 4; k++) begin
            set_mode(k, 1'b0, 1'b1);
            clear_row(oe_row(k));
            clear_row(oe_row(k) + 1);
            con(oe_row(k) + 1, 12 + k, 1);
            for (int j = 0; j < k; j++) con(oe_row(k) + 1, 12 + j, 0);
            for (int j = 0; j < k; j++) begin
                clear_row(oe_row(k) + 2 + j);
                con(oe_row(k) + 2 + j, 12 + k, 0);
                con(oe_row(k) + 2 + j, 12 + j, 1);
            end
        end
        set_mode(4, 1'b1, 1'b0);
        clear_row(oe_row(4)); con(oe_row(4), 4, 0);
        clear_row(oe_row(4) + 1); con(oe_row(4) + 1, 1, 0); con(oe_row(4) + 1, 2, 0);
        clear_row(oe_row(4) + 16); con(oe_row(4) + 16, 3, 1);
        set_mode(5, 1'b1, 1'b1);
        clear_row(oe_row(5));
        clear_row(oe_row(5) + 1); con(oe_row(5) + 1, 0, 0); con(oe_row(5) + 1, 21, 0);
        set_mode(6, 1'b0, 1'b0);
        clear_row(oe_row(6));
        clear_row(oe_row(6) + 1); con(oe_row(6) + 1, 8, 0);
        set_mode(7, 1'b0, 1'b1);
        clear_row(oe_row(7)); con(oe_row(7), 18, 0);
        clear_row(oe_row(7) + 1); con(oe_row(7) + 1, 19, 1);
        set_mode(8, 1'b1, 1'b1);
        clear_row(oe_row(8));
        clear_row(oe_row(8) + 1); con(oe_row(8) + 1, 12, 0); con(oe_row(8) + 1, 13, 0);
        set_mode(9, 1'b1, 1'b1);
    endtask

    // Program B: last-row boundaries, empty term, feedback from a pad
    task automatic build_b();
        prog = '1;
        for (int k = 0; k < 10; k++) begin
            set_mode(k, 1'b0, 1'b0);
            clear_row(oe_row(k));
        end
        set_mode(0, 1'b1, 1'b1);
        clear_row(oe_row(0) + 8); con(oe_row(0) + 8, 10, 0); con(oe_row(0) + 8, 11, 0);
        set_mode(9, 1'b1, 1'b0);
        clear_row(oe_row(9) + 8); con(oe_row(9) + 8, 10, 1);
        set_mode(5, 1'b1, 1'b1);
        clear_row(oe_row(5) + 16); con(oe_row(5) + 16, 2, 0); con(oe_row(5) + 16, 1, 1);
        set_mode(3, 1'b0, 1'b1);
        clear_row(oe_row(3) + 1);
        set_mode(1, 1'b0, 1'b0);
        clear_row(oe_row(1) + 1); con(oe_row(1) + 1, 21, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R10 watchdog: actual=still running expected=finished");
        finish_run();
    end

    initial begin
        int cnt;
        bit prev0;
        repeat (3) @(negedge clk);
        check_bit("R11 pads off in reset", |io_oe, 1'b0);
        rst_n = 1'b1;
        req = "R11";
        for (int i = 0; i < 4; i++) begin
            pin_in = 12'($urandom);
            step();
        end
        check_bit("R11 blank keeps pads off", |io_oe, 1'b0);
        pin_in = '0;
        step();

        build_a();
        load_prog();

        // R4: counter over many array clock edges
        req = "R4,R9";
        cnt = 0;
        prev0 = 1'b0;
        for (int c = 0; c < 160; c++) begin
            pin_in = '0;
            pin_in[0] = ((c / 2) % 2) == 1;
            pin_in[4] = 1'($urandom);
            pin_in[11:8] = 4'($urandom);
            io_in = 10'($urandom);
            step();
            if (pin_in[0] && !prev0) cnt++;
            prev0 = pin_in[0];
            vectors++;
            if (io_out[3:0] !== 4'(cnt)) begin
                miscompares++;
                $display("FAIL R4 counter: actual=%0d expected=%0d", io_out[3:0], 4'(cnt));
            end
        end

        // R1, R5, R9, R12 under random stimulus
        req = "R1,R5,R6,R9,R12";
        for (int c = 0; c < 400; c++) begin
            pin_in = 12'($urandom);
            pin_in[7] = ($urandom % 8) == 0;
            io_in = 10'($urandom);
            step();
        end

        // R8 then R7: preset and clear at an array clock edge
        req = "R7,R8";
        pin_in = '0;
        step();
        pin_in[0] = 1'b1; pin_in[5] = 1'b1;
        step();
        check_bit("R8 preset sets counter msb", io_out[3], 1'b1);
        check_bit("R8 preset sets counter lsb", io_out[0], 1'b1);
        check_bit("R8 preset on active-low cell", io_out[6], 1'b0);
        pin_in = '0;
        step();
        pin_in[0] = 1'b1; pin_in[5] = 1'b1; pin_in[6] = 1'b1; pin_in[7] = 1'b1;
        step();
        check_bit("R7 clear beats preset", |io_out[3:0], 1'b0);
        pin_in = '0;
        step();

        // R10: reload starts on an array clock edge
        pin_in[0] = 1'b1; pin_in[5] = 1'b1;
        build_b();
        load_prog();
        pin_in = '0;

        req = "R2,R3";
        pin_in[10] = 1'b1; pin_in[11] = 1'b1;
        step();
        check_bit("R2 last row of an 8-term cell", io_out[0], 1'b1);
        check_bit("R3 active-low combinational cell", io_out[9], 1'b1);
        pin_in[11] = 1'b0;
        step();
        check_bit("R2 last row released", io_out[0], 1'b0);
        pin_in = '0; pin_in[2] = 1'b1;
        step();
        check_bit("R2 sixteenth row of a 16-term cell", io_out[5], 1'b1);
        pin_in[0] = 1'b1;
        step();
        check_bit("R1 empty term loads one", io_out[3], 1'b1);

        req = "R1,R2,R3,R9";
        for (int c = 0; c < 300; c++) begin
            pin_in = 12'($urandom);
            io_in = 10'($urandom);
            step();
        end
        finish_run();
    end

endmodule